// File: doc/BRIEF.md
# Frame Timing and Bus-Request Generator

This block sequences one video frame of a tile display in units of CPU clock cycles. A free-running position counter steps through the frame and wraps at its end. Comparators against that position mark four things: where the CPU-accessible copy window ends, where an active-low bus request opens and closes around each of the twelve card-row fetches, where an extra fetch sits at the tail of a frame whose vertical delay is zero, and where the short active-low end-of-frame interrupt begins.

The vertical delay (3 bits) and the display enable are captured once per frame, on the clock edge that starts the frame. Each step of delay moves every row fetch two scanlines (114 cycles) later. The defaults describe a 14934-cycle frame, which is 262 scanlines of 57 cycles, with the CPU clock at a quarter of the colour-subcarrier rate.

A five-state machine drives the request and window outputs. States: ST_COPY (CPU window open), ST_GAP (display-controlled, between fetches), ST_FETCH (row fetch, request asserted), ST_TAIL (all rows fetched), ST_XFETCH (extra fetch). Transitions: ST_COPY→ST_GAP at position 3790. ST_GAP→ST_FETCH at a row's opening position when enabled. ST_FETCH→ST_GAP at the row's closing position, or ST_FETCH→ST_TAIL after row 11. ST_TAIL→ST_XFETCH at position 14877 when enabled with delay 0. Any state→ST_COPY on the last position of the frame.

Top module: `fts_frame_timer`

## Requirements
- R1: The frame position counts 0 to 14933 and then wraps to 0, so consecutive interrupt assertions are exactly 14934 cycles apart.
- R2: `cpu_window` is 1 for positions 0 to 3789 and 0 from position 3790 to the end of the frame.
- R3: For each row r from 0 to 11 with captured delay d, `busrq_n` is 0 for positions 3933+114·d+912·r up to, but not including, 4043+114·d+912·r.
- R4: The delay and enable are captured on the edge that starts a frame, and changes made during a frame have no effect on that frame's outputs.
- R5: When the captured delay is 0 and display is enabled, `busrq_n` is also 0 from position 14877 to the end of the frame (14933). With any nonzero delay there is no such extra request.
- R6: `frame_irq_n` is 0 for positions 0 to 7 of every frame that follows a completed frame, and 1 at all other times.
- R7: A captured enable of 0 keeps `busrq_n` at 1 for the whole frame, while `cpu_window` and `frame_irq_n` behave as in R2 and R6.
- R8: During reset and in the first frame after reset, `busrq_n` is 1, `frame_irq_n` is 1, and `cpu_window` follows R2. This holds because the first frame runs with delay 0 and display disabled.
- R9: An enabled frame contains exactly 12 falling edges of `busrq_n`, or 13 when its captured delay is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_en | input | 1 | Display enable, captured at frame start |
| vdelay | input | 3 | Vertical delay in scanline pairs, captured at frame start |
| busrq_n | output | 1 | Active-low bus request around each fetch |
| frame_irq_n | output | 1 | Active-low end-of-frame interrupt, 8 cycles long |
| cpu_window | output | 1 | 1 while the CPU-controlled copy window is open |

## Verification
The assertions assume that the parameters keep every window inside the frame and in order: the copy window ends before row 0 opens, each row closes before the next opens, and the extra fetch opens after the last row can close for delay 0. They place no restriction on when `disp_en` and `vdelay` may change, because both are captured at the frame boundary. The stimulus changes both inputs deliberately in the middle of each frame, so that R4 is exercised. It sweeps every delay value, a disabled frame and a return to a nonzero delay, and compares every cycle against windows computed from the equations.

// File: rtl/fts_pkg.sv
package fts_pkg;
    typedef enum logic [2:0] {
        ST_COPY   = 3'd0,
        ST_GAP    = 3'd1,
        ST_FETCH  = 3'd2,
        ST_TAIL   = 3'd3,
        ST_XFETCH = 3'd4
    } fts_state_t;
endpackage

// File: rtl/fts_pos_counter.sv
module fts_pos_counter #(
    parameter int FRAME = 14934,
    localparam int CW = $clog2(FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] pos,
    output logic          last
);
    assign last = (pos == CW'(FRAME - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pos <= '0;
        else if (last) pos <= '0;
        else           pos <= pos + 1'b1;
    end

    a_r1_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos < CW'(FRAME));
endmodule

// File: rtl/fts_window_calc.sv
module fts_window_calc #(
    parameter int CW       = 14,
    parameter int DLY_W    = 3,
    parameter int RW       = 4,
    parameter int BASE_ON  = 3933,
    parameter int BASE_OFF = 4043,
    parameter int DSTEP    = 114,
    parameter int RSTEP    = 912
) (
    input  logic [DLY_W-1:0] dly,
    input  logic [RW-1:0]    row,
    output logic [CW-1:0]    on_m1,
    output logic [CW-1:0]    off_m1
);
    localparam int SPAN = BASE_OFF - BASE_ON;
    logic [31:0] on_w;

    assign on_w   = 32'(BASE_ON) + 32'(DSTEP) * 32'(dly) + 32'(RSTEP) * 32'(row);
    assign on_m1  = CW'(on_w - 32'd1);
    assign off_m1 = CW'(on_w + 32'(SPAN) - 32'd1);
endmodule

// File: rtl/fts_irq_stretch.sv
module fts_irq_stretch #(
    parameter int HOLD = 8,
    localparam int HW = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic irq_n
);
    logic [HW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              left_q <= '0;
        else if (trig)           left_q <= HW'(HOLD);
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign irq_n = (left_q == '0);

    a_r6_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |=> !irq_n);
endmodule

// File: rtl/fts_frame_timer.sv
module fts_frame_timer #(
    parameter int FRAME    = 14934,
    parameter int SWITCH   = 3790,
    parameter int BASE_ON  = 3933,
    parameter int BASE_OFF = 4043,
    parameter int DSTEP    = 114,
    parameter int RSTEP    = 912,
    parameter int ROWS     = 12,
    parameter int XON      = 14877,
    parameter int HOLD     = 8,
    parameter int DLY_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_en,
    input  logic [DLY_W-1:0] vdelay,
    output logic             busrq_n,
    output logic             frame_irq_n,
    output logic             cpu_window
);
    import fts_pkg::*;

    localparam int CW = $clog2(FRAME);
    localparam int RW = $clog2(ROWS);

    logic [CW-1:0]    pos;
    logic             wrap;
    logic [CW-1:0]    on_m1, off_m1;
    logic [RW-1:0]    row_q;
    logic [DLY_W-1:0] dly_q;
    logic             en_q;
    logic             last_row;
    fts_state_t       st, nxt;

    fts_pos_counter #(.FRAME(FRAME)) u_pos (
        .clk(clk), .rst_n(rst_n), .pos(pos), .last(wrap)
    );

    fts_window_calc #(
        .CW(CW), .DLY_W(DLY_W), .RW(RW), .BASE_ON(BASE_ON),
        .BASE_OFF(BASE_OFF), .DSTEP(DSTEP), .RSTEP(RSTEP)
    ) u_calc (
        .dly(dly_q), .row(row_q), .on_m1(on_m1), .off_m1(off_m1)
    );

    fts_irq_stretch #(.HOLD(HOLD)) u_irq (
        .clk(clk), .rst_n(rst_n), .trig(wrap), .irq_n(frame_irq_n)
    );

    assign last_row = (row_q == RW'(ROWS - 1));

    // Frame-start capture of the delay and enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
            en_q  <= 1'b0;
        end else if (wrap) begin
            dly_q <= vdelay;
            en_q  <= disp_en;
        end
    end

    // Row index advances as each fetch closes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  row_q <= '0;
        else if (wrap)                               row_q <= '0;
        else if (st == ST_FETCH && pos == off_m1 && !last_row)
                                                     row_q <= row_q + 1'b1;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_COPY;
        else        st <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        if (wrap) begin
            nxt = ST_COPY;
        end else begin
            unique case (st)
                ST_COPY:   if (pos == CW'(SWITCH - 1)) nxt = ST_GAP;
                ST_GAP:    if (en_q && pos == on_m1) nxt = ST_FETCH;
                ST_FETCH:  if (pos == off_m1) nxt = last_row ? ST_TAIL : ST_GAP;
                ST_TAIL:   if (en_q && dly_q == '0 && pos == CW'(XON - 1))
                               nxt = ST_XFETCH;
                ST_XFETCH: nxt = ST_XFETCH;
                default:   nxt = ST_COPY;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busrq_n    = 1'b1;
        cpu_window = 1'b0;
        unique case (st)
            ST_COPY:   cpu_window = 1'b1;
            ST_FETCH:  busrq_n    = 1'b0;
            ST_XFETCH: busrq_n    = 1'b0;
            default:   ;
        endcase
    end

    a_r2_no_request_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        !busrq_n |-> !cpu_window);
    a_r3_release_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busrq_n) |-> ($past(pos) == $past(off_m1) || $past(wrap)));
    a_r5_extra_only_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_XFETCH |-> dly_q == '0);
    a_r6_irq_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_irq_n) |-> $past(wrap));
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> busrq_n);
endmodule

// File: tb/fts_frame_timer_bench.sv
module fts_frame_timer_bench;
    localparam int FRAME  = 14934;
    localparam int NFR    = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_en = 1'b0;
    logic [2:0] vdelay = 3'd0;
    logic       busrq_n, frame_irq_n, cpu_window;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fts_frame_timer u_fts_frame_timer (
        .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .vdelay(vdelay),
        .busrq_n(busrq_n), .frame_irq_n(frame_irq_n), .cpu_window(cpu_window)
    );

    function automatic bit f_en(int f);
        return !(f == 0 || f == 9);
    endfunction

    function automatic int f_dly(int f);
        if (f >= 1 && f <= 8) return f - 1;
        if (f == 10) return 5;
        return 0;
    endfunction

    function automatic bit exp_req(int f, int p);
        int d;
        if (!f_en(f)) return 1'b0;
        d = f_dly(f);
        for (int r = 0; r < 12; r++) begin
            if (p >= 3933 + 114*d + 912*r && p < 4043 + 114*d + 912*r) return 1'b1;
        end
        if (d == 0 && p >= 14877) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        int  bad_req, bad_win, bad_irq, falls, last_irq_t, fp, fr;
        bit  prev_rq;
        string rtag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset values
        check(busrq_n == 1'b1, "R8 busrq_n in reset", busrq_n, 1);
        check(frame_irq_n == 1'b1, "R8 frame_irq_n in reset", frame_irq_n, 1);
        check(cpu_window == 1'b1, "R8 cpu_window in reset", cpu_window, 1);
        disp_en = 1'b1;          // changed during reset frame: must not apply (R8/R4)
        vdelay  = 3'd3;
        rst_n   = 1'b1;
        bad_req = 0; bad_win = 0; bad_irq = 0; falls = 0; prev_rq = 1'b1;
        fp = -1; fr = -1; last_irq_t = -1;
        for (int t = 0; t < NFR*FRAME; t++) begin
            int f, p;
            bit er;
            if (t != 0) @(negedge clk);
            f = t / FRAME;
            p = t % FRAME;
            er = exp_req(f, p);
            if (busrq_n != !er) begin
                if (bad_req == 0) fr = p;
                bad_req++;
            end
            if (cpu_window != (p < 3790)) begin
                if (bad_win == 0) fp = p;
                bad_win++;
            end
            if (frame_irq_n != !(f >= 1 && p < 8)) bad_irq++;
            if (prev_rq && !busrq_n) falls++;
            prev_rq = busrq_n;
            if (p == 0 && f >= 1) begin
                // R1: interrupt spacing follows the frame length
                if (last_irq_t >= 0)
                    check(t - last_irq_t == FRAME, "R1 interrupt period", t - last_irq_t, FRAME);
                last_irq_t = t;
            end
            if (p == 7000) begin
                // R4: change inputs mid-frame; only the next frame may see them
                disp_en = f_en(f + 1);
                vdelay  = 3'(f_dly(f + 1));
            end else if (p == 9000) begin
                disp_en = ~disp_en;
                vdelay  = vdelay + 3'd1;
            end else if (p == 12000) begin
                disp_en = f_en(f + 1);
                vdelay  = 3'(f_dly(f + 1));
            end
            if (p == FRAME - 1) begin
                if (f == 0)            rtag = "R8 first frame busrq_n";
                else if (!f_en(f))     rtag = "R7 disabled frame busrq_n";
                else if (f_dly(f) == 0) rtag = "R5 R3 delay0 frame busrq_n";
                else                    rtag = "R3 R4 delayed frame busrq_n";
                check(bad_req == 0, $sformatf("%s frame %0d mismatches (first pos %0d)", rtag, f, fr), bad_req, 0);
                check(bad_win == 0, $sformatf("R2 cpu_window frame %0d mismatches (first pos %0d)", f, fp), bad_win, 0);
                check(bad_irq == 0, $sformatf("R6 frame_irq_n frame %0d mismatches", f), bad_irq, 0);
                check(falls == (f_en(f) ? (f_dly(f) == 0 ? 13 : 12) : 0),
                      $sformatf("R9 request count frame %0d", f), falls,
                      f_en(f) ? (f_dly(f) == 0 ? 13 : 12) : 0);
                bad_req = 0; bad_win = 0; bad_irq = 0; falls = 0;
            end
        end
        @(negedge clk);
        // R6: next frame begins with the interrupt asserted
        check(frame_irq_n == 1'b0, "R6 interrupt after last frame", frame_irq_n, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule